// File: doc/BRIEF.md
# Address-Transition Page Read Sequencer

This block runs the read timing of a page-mode flash array. It watches an address bus that the host drives in an asynchronous style, with a chip enable and an output enable. A change in the address is detected on an internal timebase clock. A change that moves to a new page starts a full sensing sequence. In that sequence a master pulse opens the read cycle, and a chain of later pulses follows in a fixed order. These pulses drive the selected wordline, connect the bitlines to the sense stage, enable the sense amplifier and strobe the result into a page buffer.

The sense amplifier is modelled as a data input that carries all words of the page. The latch strobe copies this input into the page buffer. A change in the low, in-page address bits after a page has been latched does not start a new sensing sequence. The selected word comes from the buffer after a much shorter access time. With 40 cycles for the first word and 10 for each further word of a four-word page, a full page averages about 18 cycles per word.

Top module: `page_read_seq`

## Requirements
- R1: While reset is held, master_o, wl_en_o, bl_conn_o, sense_en_o, latch_o and valid_o are low.
- R2: Each of the following starts a full sequence: a rising ce_i, a change in the address bits above the in-page bits, or any address change while no page is latched. The detecting clock edge counts as cycle 1, and master_o is high in cycles 1 to T_MASTER.
- R3: In a full sequence the other pulses follow in order. wl_en_o is high in cycles T_WL..T_LATCH. bl_conn_o is high in cycles T_BL..T_LATCH. sense_en_o is high in cycles T_SENSE..T_LATCH-1. latch_o is high for the single cycle T_LATCH, and that cycle captures sense_i into the page buffer.
- R4: After a full sequence, valid_o rises in cycle FULL_CYC. data_o then holds the word sensed for the page, and word j is taken from sense_i[j*DATA_W +: DATA_W], with j set by the low log2(PAGE_WORDS) address bits.
- R5: When a page is latched, a change in only the low in-page bits starts an in-page access. That access raises no master, wordline, bitline, sense or latch pulse. valid_o rises in cycle PAGE_CYC with the buffered word.
- R6: valid_o is low at once whenever addr_i differs from the last captured address, and it stays low until the access time for the new address has passed.
- R7: An address change during a sequence aborts that sequence and restarts the count from cycle 1 for the new address. This includes an in-page change made before the latch strobe, which runs as a full sequence.
- R8: valid_o is low while oe_i is low. While ce_i is low, the block returns to idle on the next edge, with all pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal timebase clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Chip enable, active high |
| oe_i | input | 1 | Output enable, active high |
| addr_i | input | ADDR_W | Word address; the low log2(PAGE_WORDS) bits pick the word in the page |
| sense_i | input | PAGE_WORDS*DATA_W | Sense amplifier outputs for the whole page |
| master_o | output | 1 | Master pulse that opens a full read |
| wl_en_o | output | 1 | Wordline enable |
| bl_conn_o | output | 1 | Bitline to sense stage connect |
| sense_en_o | output | 1 | Sense amplifier enable |
| latch_o | output | 1 | Page buffer latch strobe |
| valid_o | output | 1 | Output data valid |
| data_o | output | DATA_W | Selected word from the page buffer |

## Verification
The bench keeps the default timing of 40 cycles for a full access, 10 for an in-page access and a 34-cycle latch point. It narrows the address to 6 bits, so that 4 page-select bits sit above the 2 word bits. This makes each sensed word a direct function of the full address. Every data value can therefore be predicted and checked against the latched page. Each pulse window is checked cycle by cycle, and so is the exact cycle at which valid rises. The narrow address also makes it quick to set up an abort in the middle of a sequence, an in-page change before the latch, and a chip-enable restart at an unchanged address.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_FULL = 2'd1,
    MODE_PAGE = 2'd2
  } mode_e;
endpackage

// File: rtl/prs_atd.sv
module prs_atd #(
  parameter int ADDR_W    = 20,
  parameter int WORD_BITS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 page_ok_i,
  output logic                 start_full_o,
  output logic                 start_page_o,
  output logic                 addr_match_o,
  output logic [WORD_BITS-1:0] sel_o
);
  logic              ce_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ce_rise, addr_chg, upper_chg;

  assign ce_rise   = ce_i && !ce_q;
  assign addr_chg  = ce_i && ce_q && (addr_i != addr_q);
  assign upper_chg = addr_i[ADDR_W-1:WORD_BITS] != addr_q[ADDR_W-1:WORD_BITS];

  assign start_full_o = ce_rise || (addr_chg && (upper_chg || !page_ok_i));
  assign start_page_o = addr_chg && !upper_chg && page_ok_i;
  assign addr_match_o = (addr_i == addr_q);
  assign sel_o        = addr_q[WORD_BITS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      ce_q <= ce_i;
      if (ce_i) addr_q <= addr_i;
    end
  end

  a_r5_page_start_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_full_o && start_page_o));
endmodule

// File: rtl/prs_timer.sv
module prs_timer
  import prs_pkg::*;
#(
  parameter int FULL_CYC = 40,
  parameter int PAGE_CYC = 10,
  parameter int T_MASTER = 4,
  parameter int T_WL     = 5,
  parameter int T_BL     = 10,
  parameter int T_SENSE  = 20,
  parameter int T_LATCH  = 34
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic start_full_i,
  input  logic start_page_i,
  output logic master_o,
  output logic wl_en_o,
  output logic bl_conn_o,
  output logic sense_en_o,
  output logic latch_o,
  output logic done_o,
  output logic page_ok_o
);
  localparam int CNT_W = $clog2(FULL_CYC + 1);
  localparam logic [CNT_W-1:0] C_FULL   = CNT_W'(FULL_CYC);
  localparam logic [CNT_W-1:0] C_PAGE   = CNT_W'(PAGE_CYC);
  localparam logic [CNT_W-1:0] C_MASTER = CNT_W'(T_MASTER);
  localparam logic [CNT_W-1:0] C_WL     = CNT_W'(T_WL);
  localparam logic [CNT_W-1:0] C_BL     = CNT_W'(T_BL);
  localparam logic [CNT_W-1:0] C_SENSE  = CNT_W'(T_SENSE);
  localparam logic [CNT_W-1:0] C_LATCH  = CNT_W'(T_LATCH);

  mode_e            mode_q;
  logic [CNT_W-1:0] cnt_q, lim;
  logic             page_ok_q, full;

  assign full = (mode_q == MODE_FULL);
  assign lim  = (mode_q == MODE_PAGE) ? C_PAGE : C_FULL;

  // pulse windows decoded from the cycle count of the running sequence
  assign master_o   = full && (cnt_q <= C_MASTER);
  assign wl_en_o    = full && (cnt_q >= C_WL)    && (cnt_q <= C_LATCH);
  assign bl_conn_o  = full && (cnt_q >= C_BL)    && (cnt_q <= C_LATCH);
  assign sense_en_o = full && (cnt_q >= C_SENSE) && (cnt_q <  C_LATCH);
  assign latch_o    = full && (cnt_q == C_LATCH);
  assign done_o     = (mode_q != MODE_IDLE) && (cnt_q == lim);
  assign page_ok_o  = page_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_IDLE;
      cnt_q     <= '0;
      page_ok_q <= 1'b0;
    end else if (!ce_i) begin
      mode_q    <= MODE_IDLE;
      cnt_q     <= '0;
      page_ok_q <= 1'b0;
    end else if (start_full_i) begin
      mode_q    <= MODE_FULL;
      cnt_q     <= CNT_W'(1);
      page_ok_q <= 1'b0;
    end else if (start_page_i) begin
      mode_q <= MODE_PAGE;
      cnt_q  <= CNT_W'(1);
    end else begin
      if (latch_o) page_ok_q <= 1'b1;
      if (mode_q != MODE_IDLE && cnt_q < lim) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  a_r3_latch_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> !latch_o);
  a_r3_sense_inside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_en_o |-> (wl_en_o && bl_conn_o));
  a_r2_master_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_o |-> !(wl_en_o || bl_conn_o || sense_en_o));
  a_r3_latch_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_o && ce_i && !start_full_i && !start_page_i) |=> page_ok_o);
endmodule

// File: rtl/prs_page_buf.sv
module prs_page_buf #(
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 4,
  parameter int WORD_BITS  = $clog2(PAGE_WORDS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         capture_i,
  input  logic [PAGE_WORDS*DATA_W-1:0] page_i,
  input  logic [WORD_BITS-1:0]         sel_i,
  output logic [DATA_W-1:0]            word_o
);
  logic [PAGE_WORDS*DATA_W-1:0] words_flat;

  for (genvar w = 0; w < PAGE_WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        word_q <= '0;
      else if (capture_i) word_q <= page_i[w*DATA_W +: DATA_W];
    end
    assign words_flat[w*DATA_W +: DATA_W] = word_q;
  end

  assign word_o = words_flat[int'(sel_i)*DATA_W +: DATA_W];
endmodule

// File: rtl/page_read_seq.sv
module page_read_seq #(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 4,
  parameter int FULL_CYC   = 40,
  parameter int PAGE_CYC   = 10,
  parameter int T_MASTER   = 4,
  parameter int T_WL       = 5,
  parameter int T_BL       = 10,
  parameter int T_SENSE    = 20,
  parameter int T_LATCH    = 34
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         ce_i,
  input  logic                         oe_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [PAGE_WORDS*DATA_W-1:0] sense_i,
  output logic                         master_o,
  output logic                         wl_en_o,
  output logic                         bl_conn_o,
  output logic                         sense_en_o,
  output logic                         latch_o,
  output logic                         valid_o,
  output logic [DATA_W-1:0]            data_o
);
  localparam int WORD_BITS = $clog2(PAGE_WORDS);

  logic                 start_full, start_page, addr_match, done, page_ok;
  logic [WORD_BITS-1:0] sel;

  prs_atd #(.ADDR_W(ADDR_W), .WORD_BITS(WORD_BITS)) i_atd (
    .clk_i, .rst_ni, .ce_i, .addr_i,
    .page_ok_i   (page_ok),
    .start_full_o(start_full),
    .start_page_o(start_page),
    .addr_match_o(addr_match),
    .sel_o       (sel)
  );

  prs_timer #(
    .FULL_CYC(FULL_CYC), .PAGE_CYC(PAGE_CYC), .T_MASTER(T_MASTER),
    .T_WL(T_WL), .T_BL(T_BL), .T_SENSE(T_SENSE), .T_LATCH(T_LATCH)
  ) i_timer (
    .clk_i, .rst_ni, .ce_i,
    .start_full_i(start_full),
    .start_page_i(start_page),
    .master_o, .wl_en_o, .bl_conn_o, .sense_en_o, .latch_o,
    .done_o      (done),
    .page_ok_o   (page_ok)
  );

  prs_page_buf #(.DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS), .WORD_BITS(WORD_BITS)) i_buf (
    .clk_i, .rst_ni,
    .capture_i(latch_o),
    .page_i   (sense_i),
    .sel_i    (sel),
    .word_o   (data_o)
  );

  // an undetected address change masks valid in the same cycle
  assign valid_o = oe_i && ce_i && done && addr_match;

  a_r4_valid_needs_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> page_ok);
  a_r5_inpage_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_page |=> !(master_o || sense_en_o || latch_o));
  a_r8_ce_low_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> !(master_o || wl_en_o || latch_o));
  a_r2_restart_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_full |=> master_o);
endmodule

// File: tb/test_page_read_seq.sv
`timescale 1ns/1ps
module test_page_read_seq;
  localparam int AW = 6, DW = 16, PW = 4;
  localparam int FC = 40, PC = 10, TM = 4, TWL = 5, TBL = 10, TS = 20, TL = 34;

  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, oe = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic [PW*DW-1:0] sense;
  logic master, wl, bl, se, lt, valid;
  logic [DW-1:0] data;

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] exp_word(logic [AW-1:0] a);
    return {4'hA, a, ~a};
  endfunction

  always_comb
    for (int j = 0; j < PW; j++) sense[j*DW +: DW] = exp_word({addr[AW-1:2], 2'(j)});

  page_read_seq #(.ADDR_W(AW), .DATA_W(DW), .PAGE_WORDS(PW), .FULL_CYC(FC), .PAGE_CYC(PC),
    .T_MASTER(TM), .T_WL(TWL), .T_BL(TBL), .T_SENSE(TS), .T_LATCH(TL)) i_page_read_seq (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .oe_i(oe), .addr_i(addr), .sense_i(sense),
    .master_o(master), .wl_en_o(wl), .bl_conn_o(bl), .sense_en_o(se), .latch_o(lt),
    .valid_o(valid), .data_o(data));

  typedef struct {logic [AW-1:0] a; int start; int lat;} item_t;
  item_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit reported = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: compare each rising valid against the oldest expected access
  initial begin
    bit    prev;
    item_t it;
    prev = 1'b0;
    forever begin
      @(negedge clk); #1;
      if (valid && !prev && exp_q.size() > 0) begin
        it = exp_q.pop_front();
        check(cyc - it.start == it.lat, it.lat == FC ? "R4" : "R5", "latency",
              cyc - it.start, it.lat);
        check(data == exp_word(it.a), it.lat == FC ? "R4" : "R5", "data",
              int'(data), int'(exp_word(it.a)));
      end
      prev = valid;
    end
  end

  task automatic drive(logic [AW-1:0] a, bit push, int lat);
    @(negedge clk);
    ce   = 1'b1;
    addr = a;
    if (push) exp_q.push_back('{a, cyc, lat});
  endtask

  // cycle i counts posedges since the drive; full picks the pulse pattern
  task automatic run(int n, bit full, int lat);
    logic [4:0] expv, act;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); #1;
      expv = full ? {1'(i <= TM), 1'(i >= TWL && i <= TL), 1'(i >= TBL && i <= TL),
                     1'(i >= TS && i < TL), 1'(i == TL)} : 5'b0;
      act  = {master, wl, bl, se, lt};
      check(act == expv, full ? "R2/R3" : "R5", "pulses", int'(act), int'(expv));
      check(valid == (i >= lat), "R6", "valid timing", int'(valid), int'(i >= lat));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({master, wl, bl, se, lt, valid} == 6'b0, "R1", "reset outputs",
          int'({master, wl, bl, se, lt, valid}), 0);
    rst_n = 1'b1;
    oe    = 1'b1;

    drive(6'h00, 1'b1, FC); run(FC + 2, 1'b1, FC);
    for (int w = 1; w < 4; w++) begin
      drive(6'(w), 1'b1, PC);
      #1 check(valid == 1'b0, "R6", "valid at in-page change", int'(valid), 0);
      run(PC + 2, 1'b0, PC);
    end

    drive(6'h15, 1'b1, FC); run(FC + 2, 1'b1, FC);
    drive(6'h16, 1'b1, PC); run(PC + 2, 1'b0, PC);

    // R7: abort in mid-sequence on an upper change
    drive(6'h20, 1'b0, 0);  run(15, 1'b1, FC);
    drive(6'h30, 1'b1, FC); run(FC + 2, 1'b1, FC);

    // R7: in-page change before the latch runs as a full sequence
    drive(6'h08, 1'b0, 0);  run(5, 1'b1, FC);
    drive(6'h09, 1'b1, FC); run(FC + 2, 1'b1, FC);
    drive(6'h0B, 1'b1, PC); run(PC + 2, 1'b0, PC);

    @(negedge clk); oe = 1'b0;
    #1 check(valid == 1'b0, "R8", "valid with oe low", int'(valid), 0);
    @(negedge clk); oe = 1'b1;
    #1 check(valid == 1'b1 && data == exp_word(6'h0B), "R8", "valid with oe restored",
             int'(valid), 1);

    @(negedge clk); ce = 1'b0;
    run(4, 1'b0, 1000);

    // R2: chip enable rising at an unchanged address re-senses the page
    drive(6'h0B, 1'b1, FC); run(FC + 2, 1'b1, FC);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4", "unserved accesses", exp_q.size(), 0);
    report();
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule